// File: doc/BRIEF.md
# Fifth-Order Shift-and-Add Delta-Sigma Modulator

This block turns a high-rate stream of signed multibit audio samples into a one-bit density stream for each of two channels. It runs once per sample strobe, which comes at 256 times the base audio rate. Each channel has its own fifth-order noise-shaping loop in the cascade-of-resonators-feedback arrangement. That loop has one leading integrator and two resonator pairs. Each resonator pair closes a small local feedback (a g term) from its second integrator back to its first.

Every coefficient product is built from at most three signed power-of-two digits, so the arithmetic uses only shifts and adds. A 32-bit maximal-length shift register supplies a few bits of dither. The dither is added to the last integrator's value before the sign decision. Each integrator clamps at a symmetric limit instead of wrapping around, so the loop recovers after an overload.

Upstream logic drives a sample and a one-cycle strobe. The one-bit results appear one clock later, together with a valid pulse.

Top module: `dsm_crfb5`

## Requirements
- R1: While reset is high, and in the cycle after it, `dsd_vld`, `dsd_l` and `dsd_r` are 0. Reset clears all ten integrators to 0 and loads the dither register with `SEED`.
- R2: On each strobe, a channel's output bit is 1 when (x5 + dither) >= 0 and 0 otherwise. x5 is that channel's last integrator before the update. The value fed back is +2^(IN_W-1) for a 1 and -2^(IN_W-1) for a 0.
- R3: After every update, each integrator lies within [-SAT_LIM, +SAT_LIM]. A result beyond the limit is clamped to that limit.
- R4: A coefficient is three 8-bit digits packed into 24 bits. In each digit, bits [7:6]=01 adds (x >>> s), bits [7:6]=11 subtracts it, and any other code contributes nothing. The shift s is bits [4:0], and >>> is an arithmetic shift that rounds toward minus infinity.
- R5: One strobe updates the integrators in this order, where fb is the fed-back value and u the input:
  - x1 += b·u − a1·fb
  - x2 += c1·x1 − g1·x3 − a2·fb
  - x3 += c2·x2new − a3·fb
  - x4 += c3·x3 − g2·x5 − a4·fb
  - x5 += c4·x4new − a5·fb

  Terms without "new" use the values from before the update.
- R6: The dither register shifts left once per strobe. Its new bit 0 is the XOR of bits 31, 21, 1 and 0. The dither for the left channel is bits [DW-1:0] and for the right channel bits [16+DW-1:16], each read as a signed two's-complement value.
- R7: After a second reset, the same input sequence reproduces the same output bit sequence.
- R8: In cycles without a strobe, integrators, dither register and output bits hold. `dsd_vld` is 0 and the sample inputs have no effect.
- R9: The two channels are independent loops. Each depends only on its own input and its own dither slice.
- R10: `dsd_vld` is high in exactly the cycle after each strobe cycle. Strobes in consecutive cycles are all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe: accept a sample pair |
| pcm_l | input | IN_W | Left sample, signed |
| pcm_r | input | IN_W | Right sample, signed |
| dsd_l | output | 1 | Left one-bit output |
| dsd_r | output | 1 | Right one-bit output |
| dsd_vld | output | 1 | High the cycle after a strobe |

## Verification
The sign decision and integrator clamping can fall in the same update. Both also interact with back-to-back strobes, where one update feeds the next with no idle cycle between them. Long runs at positive and negative full scale, plus alternating extremes, drive the integrators into their limits while strobes arrive every cycle. Each output bit is then compared with a bench model that clamps and quantises in its own arithmetic. A miss in either the clamp or the order of updates shows up as a differing bit stream within a few samples.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef logic signed [63:0] acc_t;

  // one coefficient: three digits {code[1:0], 1'b0, shift[4:0]}
  function automatic acc_t csd_mul(input acc_t x, input logic [23:0] coef);
    acc_t r;
    logic [7:0] d;
    r = '0;
    for (int i = 0; i < 3; i++) begin
      d = coef[8*i +: 8];
      if (d[7:6] == 2'b01)      r = r + (x >>> d[4:0]);
      else if (d[7:6] == 2'b11) r = r - (x >>> d[4:0]);
    end
    return r;
  endfunction

  function automatic acc_t clamp(input acc_t v, input acc_t lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/dsm_lfsr.sv
module dsm_lfsr #(
  parameter logic [31:0] SEED = 32'hACE1_2468
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  output logic [31:0] state
);
  logic fb_bit;

  assign fb_bit = state[31] ^ state[21] ^ state[1] ^ state[0];

  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= {state[30:0], fb_bit};
  end

  assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (rst)
    state != 32'd0);
  assert_lfsr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state));

endmodule

// File: rtl/dsm_loop.sv
module dsm_loop
  import dsm_pkg::*;
#(
  parameter int          IN_W    = 24,
  parameter int          ST_W    = 30,
  parameter int          DW      = 4,
  parameter acc_t        SAT_LIM = 64'sd268435456,
  parameter logic [23:0] CB  = 24'h000043,
  parameter logic [23:0] CA1 = 24'h000043,
  parameter logic [23:0] CA2 = 24'h000045,
  parameter logic [23:0] CA3 = 24'h000046,
  parameter logic [23:0] CA4 = 24'h000047,
  parameter logic [23:0] CA5 = 24'h000048,
  parameter logic [23:0] CC1 = 24'h00C240,
  parameter logic [23:0] CC2 = 24'h000041,
  parameter logic [23:0] CC3 = 24'h000041,
  parameter logic [23:0] CC4 = 24'h0043C1,
  parameter logic [23:0] CG1 = 24'h000048,
  parameter logic [23:0] CG2 = 24'h000049
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   strobe,
  input  logic signed [IN_W-1:0] u,
  input  logic signed [DW-1:0]   dith,
  output logic                   bit_q
);
  localparam int   NST = 5;
  localparam acc_t FS  = acc_t'(64'sd1 <<< (IN_W - 1));

  logic [NST-1:0][ST_W-1:0] st;
  acc_t xs [NST];
  acc_t nx [NST];
  acc_t uu, dv, fb, qsum;
  logic q;

  always_comb begin
    for (int k = 0; k < NST; k++) xs[k] = acc_t'($signed(st[k]));
    uu   = acc_t'(u);
    dv   = acc_t'(dith);
    qsum = xs[4] + dv;
    q    = !qsum[63];
    fb   = q ? FS : -FS;
    nx[0] = clamp(xs[0] + csd_mul(uu, CB) - csd_mul(fb, CA1), SAT_LIM);
    nx[1] = clamp(xs[1] + csd_mul(xs[0], CC1) - csd_mul(xs[2], CG1)
                  - csd_mul(fb, CA2), SAT_LIM);
    nx[2] = clamp(xs[2] + csd_mul(nx[1], CC2) - csd_mul(fb, CA3), SAT_LIM);
    nx[3] = clamp(xs[3] + csd_mul(xs[2], CC3) - csd_mul(xs[4], CG2)
                  - csd_mul(fb, CA4), SAT_LIM);
    nx[4] = clamp(xs[4] + csd_mul(nx[3], CC4) - csd_mul(fb, CA5), SAT_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= '0;
      bit_q <= 1'b0;
    end else if (strobe) begin
      for (int k = 0; k < NST; k++) st[k] <= nx[k][ST_W-1:0];
      bit_q <= q;
    end
  end

  generate
    for (genvar k = 0; k < NST; k++) begin : g_chk
      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (xs[k] <= SAT_LIM) && (xs[k] >= -SAT_LIM));
    end
  endgenerate

  assert_decision_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (bit_q == $past(q)));
  assert_state_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(st) && $stable(bit_q)));

endmodule

// File: rtl/dsm_crfb5.sv
module dsm_crfb5
  import dsm_pkg::*;
#(
  parameter int          IN_W    = 24,
  parameter int          ST_W    = 30,
  parameter int          DW      = 4,
  parameter acc_t        SAT_LIM = 64'sd268435456,
  parameter logic [31:0] SEED    = 32'hACE1_2468
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_stb,
  input  logic [IN_W-1:0] pcm_l,
  input  logic [IN_W-1:0] pcm_r,
  output logic            dsd_l,
  output logic            dsd_r,
  output logic            dsd_vld
);
  localparam int NCH       = 2;
  localparam int DITH_STEP = 16;

  logic [31:0]         lfsr;
  logic [NCH-1:0][IN_W-1:0] pcm;
  logic [NCH-1:0]      bits;

  assign pcm[0] = pcm_l;
  assign pcm[1] = pcm_r;

  dsm_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .adv(smp_stb), .state(lfsr)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      dsm_loop #(
        .IN_W(IN_W), .ST_W(ST_W), .DW(DW), .SAT_LIM(SAT_LIM)
      ) u_loop (
        .clk(clk), .rst(rst), .strobe(smp_stb),
        .u($signed(pcm[c])),
        .dith($signed(lfsr[DITH_STEP*c +: DW])),
        .bit_q(bits[c])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dsd_vld <= 1'b0;
    else     dsd_vld <= smp_stb;
  end

  assign dsd_l = bits[0];
  assign dsd_r = bits[1];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!dsd_vld && !dsd_l && !dsd_r));
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> dsd_vld);
  assert_valid_only_R10: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> !dsd_vld);

endmodule

// File: tb/test_dsm_crfb5.sv
module test_dsm_crfb5;
  localparam int    IN_W = 24;
  localparam int    DW   = 4;
  localparam longint LIM = 64'sd268435456;
  localparam longint FS  = 64'sd1 <<< (IN_W - 1);
  localparam logic [31:0] SEED = 32'hACE1_2468;
  // coefficient defaults: b, a1..a5, c1..c4, g1, g2
  localparam logic [23:0] K_B = 24'h000043;
  localparam logic [23:0] K_A [5] = '{24'h000043, 24'h000045, 24'h000046,
                                      24'h000047, 24'h000048};
  localparam logic [23:0] K_C [4] = '{24'h00C240, 24'h000041, 24'h000041,
                                      24'h0043C1};
  localparam logic [23:0] K_G1 = 24'h000048;
  localparam logic [23:0] K_G2 = 24'h000049;

  logic clk = 0, rst = 1, smp_stb = 0;
  logic [IN_W-1:0] pcm_l = '0, pcm_r = '0;
  logic dsd_l, dsd_r, dsd_vld;

  int total = 0, bad = 0;
  longint mx [2][5];
  logic [31:0] mlf;
  logic exp_l = 0, exp_r = 0;
  logic rec [64][2];

  always #4 clk = ~clk;

  dsm_crfb5 i_dsm_crfb5 (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .pcm_l(pcm_l), .pcm_r(pcm_r),
    .dsd_l(dsd_l), .dsd_r(dsd_r), .dsd_vld(dsd_vld)
  );

  function automatic longint floor_shr(longint x, int s);
    longint p = 64'sd1 <<< s;
    if (x >= 0) return x / p;
    return -((-x + p - 1) / p);
  endfunction

  function automatic longint times(longint x, logic [23:0] k);
    longint acc = 0;
    for (int i = 0; i < 3; i++) begin
      int sh = int'(k[8*i +: 5]);
      case (k[8*i+6 +: 2])
        2'b01: acc += floor_shr(x, sh);
        2'b11: acc -= floor_shr(x, sh);
        default: ;
      endcase
    end
    return acc;
  endfunction

  function automatic longint lim(longint v);
    return (v > LIM) ? LIM : ((v < -LIM) ? -LIM : v);
  endfunction

  function automatic longint dith_of(logic [31:0] s, int c);
    longint d = longint'(s[16*c +: DW]);
    if (d >= (64'sd1 <<< (DW - 1))) d -= (64'sd1 <<< DW);
    return d;
  endfunction

  function automatic longint sext(logic [IN_W-1:0] v);
    longint r = longint'(v);
    if (v[IN_W-1]) r -= (64'sd1 <<< IN_W);
    return r;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) for (int k = 0; k < 5; k++) mx[c][k] = 0;
    mlf = SEED;
  endtask

  task automatic model_step(logic [IN_W-1:0] ul, logic [IN_W-1:0] ur);
    logic qb [2];
    for (int c = 0; c < 2; c++) begin
      longint u = sext(c == 0 ? ul : ur);
      longint f, o1, o2, o3, o4, o5;
      qb[c] = (mx[c][4] + dith_of(mlf, c)) >= 0;
      f  = qb[c] ? FS : -FS;
      o1 = lim(mx[c][0] + times(u, K_B) - times(f, K_A[0]));
      o2 = lim(mx[c][1] + times(mx[c][0], K_C[0]) - times(mx[c][2], K_G1) - times(f, K_A[1]));
      o3 = lim(mx[c][2] + times(o2, K_C[1]) - times(f, K_A[2]));
      o4 = lim(mx[c][3] + times(mx[c][2], K_C[2]) - times(mx[c][4], K_G2) - times(f, K_A[3]));
      o5 = lim(mx[c][4] + times(o4, K_C[3]) - times(f, K_A[4]));
      mx[c][0] = o1; mx[c][1] = o2; mx[c][2] = o3; mx[c][3] = o4; mx[c][4] = o5;
    end
    exp_l = qb[0];
    exp_r = qb[1];
    mlf = {mlf[30:0], mlf[31] ^ mlf[21] ^ mlf[1] ^ mlf[0]};
  endtask

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge with the result checked
  task automatic strobe(logic [IN_W-1:0] l, logic [IN_W-1:0] r, string req);
    smp_stb = 1; pcm_l = l; pcm_r = r;
    model_step(l, r);
    @(negedge clk);
    smp_stb = 0;
    chk({req, " left bit"}, dsd_l, exp_l);
    chk({req, " right bit"}, dsd_r, exp_r);
    chk("R10 valid", dsd_vld, 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      pcm_l = IN_W'($urandom); pcm_r = IN_W'($urandom);
      @(negedge clk);
      chk("R8 valid low when idle", dsd_vld, 0);
      chk("R8 left holds", dsd_l, exp_l);
      chk("R8 right holds", dsd_r, exp_r);
    end
  endtask

  task automatic do_reset();
    rst = 1; smp_stb = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", dsd_vld, 0);
    chk("R1 left in reset", dsd_l, 0);
    chk("R1 right in reset", dsd_r, 0);
    rst = 0;
    model_reset();
    exp_l = 0; exp_r = 0;
    @(negedge clk);
    chk("R1 valid after reset", dsd_vld, 0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R2 R6: zero input, dither alone steers the first decisions
    for (int i = 0; i < 64; i++) begin
      strobe('0, '0, "R2 R6 zero input");
      rec[i][0] = dsd_l; rec[i][1] = dsd_r;
    end
    // R4 R5 R9: random independent channels, random gaps
    for (int i = 0; i < 1500; i++) begin
      logic [IN_W-1:0] l = IN_W'($urandom) >> 2;
      logic [IN_W-1:0] r = IN_W'($urandom) >> 1;
      if (l[IN_W-3]) l = l | {2'b11, {(IN_W-2){1'b0}}};
      strobe(l, r, "R4 R5 R9 random");
      if ($urandom_range(3) == 0) idle($urandom_range(2, 1));
    end
    // R3: overload both ways, back-to-back strobes
    for (int i = 0; i < 300; i++)
      strobe({1'b0, {(IN_W-1){1'b1}}}, {1'b1, {(IN_W-1){1'b0}}}, "R3 full scale");
    for (int i = 0; i < 200; i++)
      strobe(i[0] ? {1'b0, {(IN_W-1){1'b1}}} : {1'b1, {(IN_W-1){1'b0}}},
             i[1] ? {1'b1, {(IN_W-1){1'b0}}} : {1'b0, {(IN_W-1){1'b1}}},
             "R3 alternating extremes");
    for (int i = 0; i < 300; i++)
      strobe('0, {1'b0, {(IN_W-1){1'b1}}}, "R3 R9 recovery");
    idle(4);
    // R7: reset again, replay, compare to the first run
    do_reset();
    for (int i = 0; i < 64; i++) begin
      strobe('0, '0, "R7 replay");
      chk("R7 left repeat", dsd_l, rec[i][0]);
      chk("R7 right repeat", dsd_r, rec[i][1]);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule